// File: doc/BRIEF.md
# Byte-Order-Aware Load Result Formatter

This block sits on the load path between a 32-bit data memory read port and the register file. It turns the word returned by memory into the value written back to a register. For a word access it passes the word through unchanged. For a byte access it picks one byte lane and widens that byte to the full register width, either with zeros or with copies of the byte's top bit.

Which lane a byte address selects depends on the byte-order mode. In little-endian order the lowest address holds the least significant byte. In big-endian order the lowest address holds the most significant byte. Bytes 0 to 3 make up the first word and bytes 4 to 7 the second, so only the two low address bits reach this block.

The mode comes from a configuration pin. The block copies that pin on every clock edge while reset is held, and ignores the pin once reset has been released. A mode register that never sees reset starts in little-endian order.

Top module: `load_formatter`

## Requirements
- R1: In little-endian mode (latched pin value 0), a byte access at offset k (`addr_lo`, 0 to 3) takes bits 8k+7:8k of `rd_word`.
- R2: In big-endian mode (latched pin value 1), a byte access at offset k takes bits 31-8k:24-8k of `rd_word`.
- R3: On each rising clock edge with `rst_n` low, the mode takes the value of `cfg_big_endian`. The value present at the last edge of reset decides the mode.
- R4: After `rst_n` goes high, changes on `cfg_big_endian` have no effect on the mode. This is seen in the lane that later byte accesses select.
- R5: An unsigned byte access (`acc_word`=0, `sign_ext`=0) puts the byte in bits 7:0 and sets bits 31:8 to zero.
- R6: A signed byte access (`acc_word`=0, `sign_ext`=1) puts the byte in bits 7:0 and fills bits 31:8 with bit 7 of the byte.
- R7: A word access (`acc_word`=1) returns `rd_word` unchanged in both modes, whatever the values of `addr_lo` and `sign_ext`.
- R8: If reset has not yet been asserted, the block works in little-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| cfg_big_endian | input | 1 | Byte-order selection pin: 1 = big-endian, 0 = little-endian |
| rd_word | input | 32 | Word from the memory read port |
| addr_lo | input | 2 | Byte offset within the word |
| acc_word | input | 1 | Access size: 1 = word, 0 = byte |
| sign_ext | input | 1 | Extension for byte accesses: 1 = signed, 0 = unsigned |
| load_value | output | 32 | Formatted value for the register file |

## Verification
The bench builds the block with its default parameters: a 32-bit word and 8-bit bytes, which gives four lanes. At this size a full sweep of every offset, in both byte orders and with both extension kinds, is short enough to cover every lane and fill case.

The data patterns include bytes with the top bit set and bytes with it clear, so that zero fill and sign fill give different results. The bench toggles the configuration pin during reset and again after reset is released, and then checks the lane that byte accesses select.

// File: rtl/load_fmt_pkg.sv
// Shared types for the load result formatter.
// Assumes: access size is coded on one bit, 0 = byte, 1 = word.
package load_fmt_pkg;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_size_e;

    typedef enum logic {
        ORDER_LITTLE = 1'b0,
        ORDER_BIG    = 1'b1
    } byte_order_e;

endpackage

// File: rtl/order_mode_reg.sv
// Holds the byte-order mode. It follows the configuration pin on every edge
// while the synchronous active-low reset is held, and keeps its value after that.
// Assumes: with no reset at all, the register starts in little-endian order.
module order_mode_reg
    import load_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_pin,
    output byte_order_e order_o
);

    byte_order_e order_q = ORDER_LITTLE;

    // Follow the pin only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= byte_order_e'(cfg_pin);
        end
    end

    assign order_o = order_q;

    // R3: the mode reflects the pin value from the previous edge of reset.
    p_capture_in_reset_r3: assert property (@(posedge clk)
        !rst_n |=> (order_o == byte_order_e'($past(cfg_pin))));

    // R4: the mode stays fixed for as long as reset stays released.
    p_locked_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(order_o));

endmodule

// File: rtl/byte_lane_pick.sv
// Picks one byte lane of a word. The chosen lane depends on the byte offset
// and the byte-order mode.
// Assumes: DATA_W is a whole multiple of BYTE_W and the lane count is a power of two.
module byte_lane_pick
    import load_fmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  byte_order_e       order_i,
    output logic [BYTE_W-1:0] byte_o
);

    localparam logic [OFF_W-1:0] LAST_LANE = OFF_W'(LANES - 1);

    logic [BYTE_W-1:0] lanes [LANES];
    logic [OFF_W-1:0]  lane_idx;

    // Split the word into lanes, with lane 0 the least significant.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    // Big-endian order reverses the offset: the lowest address is the top lane.
    always_comb begin
        lane_idx = (order_i == ORDER_BIG) ? (LAST_LANE - off_i) : off_i;
    end

    assign byte_o = lanes[lane_idx];

endmodule

// File: rtl/byte_widen.sv
// Widens a byte to the full register width, with zero fill or sign fill.
// Assumes: DATA_W > BYTE_W.
module byte_widen #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int FILL_W = DATA_W - BYTE_W
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] value_o
);

    logic fill_bit;

    // The fill bit is the byte's top bit for signed loads and zero otherwise.
    always_comb begin
        fill_bit = signed_i & byte_i[BYTE_W-1];
        value_o  = {{FILL_W{fill_bit}}, byte_i};
    end

endmodule

// File: rtl/load_formatter.sv
// Top of the load result formatter. For a word access the read word passes
// through; for a byte access one lane is chosen and widened to the register width.
// Assumes: only aligned word and byte accesses reach this block.
module load_formatter
    import load_fmt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_big_endian,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic              acc_word,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] load_value
);

    byte_order_e       order;
    logic [BYTE_W-1:0] picked;
    logic [DATA_W-1:0] widened;
    acc_size_e         acc_size;

    assign acc_size = acc_size_e'(acc_word);

    order_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_pin (cfg_big_endian),
        .order_o (order)
    );

    byte_lane_pick #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pick (
        .word_i  (rd_word),
        .off_i   (addr_lo),
        .order_i (order),
        .byte_o  (picked)
    );

    byte_widen #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_widen (
        .byte_i   (picked),
        .signed_i (sign_ext),
        .value_o  (widened)
    );

    // Choose between the word as read and the widened byte.
    always_comb begin
        load_value = (acc_size == ACC_WORD) ? rd_word : widened;
    end

    // R5: unsigned byte loads leave every bit above the byte at zero.
    p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_word && !sign_ext) |-> (load_value[DATA_W-1:BYTE_W] == '0));

    // R6: signed byte loads copy bit 7 of the result into every upper bit.
    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_word && sign_ext) |->
        (load_value[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){load_value[BYTE_W-1]}}));

    // R7: word loads return the read word unchanged.
    p_word_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_word |-> (load_value == rd_word));

endmodule

// File: tb/load_formatter_test.sv
`timescale 1ns/1ps
module load_formatter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cfg_big_endian = 1'b0;
    logic [31:0] rd_word = '0;
    logic [1:0]  addr_lo = '0;
    logic        acc_word = 1'b0;
    logic        sign_ext = 1'b0;
    logic [31:0] load_value;

    int checks = 0;
    int fails  = 0;
    bit ref_big = 1'b0;   // reference mode; starts little-endian (R8)

    always #2 clk = ~clk; // 250 MHz

    load_formatter uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_big_endian (cfg_big_endian),
        .rd_word        (rd_word),
        .addr_lo        (addr_lo),
        .acc_word       (acc_word),
        .sign_ext       (sign_ext),
        .load_value     (load_value)
    );

    // Reference model of the mode: the pin is copied on edges during reset.
    always @(posedge clk) begin
        if (!rst_n) ref_big <= cfg_big_endian;
    end

    function automatic logic [31:0] expect_val(input logic [31:0] w, input int off,
                                               input bit wd, input bit sg, input bit big);
        int b;
        int pos;
        if (wd) return w;
        pos = big ? (3 - off) : off;
        b = (w / (1 << (8 * pos))) % 256;
        if (sg && b >= 128) b = b - 256;
        return 32'(b);
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        checks++;
        if (load_value !== exp) begin
            fails++;
            $display("FAIL %s: word=%h off=%0d word_acc=%0b signed=%0b got %h expected %h",
                     tag, rd_word, addr_lo, acc_word, sign_ext, load_value, exp);
        end
    endtask

    // Apply one access after a clock edge and check it at the falling edge.
    task automatic access(input logic [31:0] w, input int off, input bit wd, input bit sg,
                          input string tag);
        @(posedge clk);
        #1;
        rd_word  = w;
        addr_lo  = 2'(off);
        acc_word = wd;
        sign_ext = sg;
        @(negedge clk);
        check(tag, expect_val(w, off, wd, sg, ref_big));
    endtask

    task automatic sweep(input logic [31:0] w, input string order_tag);
        for (int k = 0; k < 4; k++) begin
            access(w, k, 1'b0, 1'b0, {order_tag, "/R5"});
            access(w, k, 1'b0, 1'b1, {order_tag, "/R6"});
        end
        access(w, 2, 1'b1, 1'b1, "R7");
        access(w, 1, 1'b1, 1'b0, "R7");
    endtask

    task automatic do_reset(input bit pin_first, input bit pin_last);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        cfg_big_endian = pin_first;
        repeat (2) @(posedge clk);
        #1;
        cfg_big_endian = pin_last;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R8: no reset yet, so the block must use little-endian order.
        sweep(32'h8134_F27A, "R8");

        // R3: the last pin value during reset wins (1 then 0 gives little-endian).
        do_reset(1'b1, 1'b0);
        sweep(32'h12F4_5687, "R3/R1");

        // R2: reset with the pin high selects big-endian order.
        do_reset(1'b0, 1'b1);
        sweep(32'h9A3C_E10F, "R2");

        // R4: dropping the pin after reset must not change the lane order.
        @(posedge clk);
        #1;
        cfg_big_endian = 1'b0;
        repeat (3) @(posedge clk);
        sweep(32'h0180_7FFE, "R4/R2");

        // R1: back to little-endian, then raise the pin after reset.
        do_reset(1'b0, 1'b0);
        @(posedge clk);
        #1;
        cfg_big_endian = 1'b1;
        sweep(32'hC0DE_5AA5, "R4/R1");
        sweep(32'h7F80_00FF, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule